// File: doc/BRIEF.md
# Sigma-Delta Integrate-and-Fire Encoder

This block turns a stream of signed samples into a one-bit spike train. It works as a discrete-time integrate-and-fire neuron with no leak, and that makes it a first-order, single-bit sigma-delta modulator. Each accepted sample is added to a signed membrane accumulator. When the accumulator reaches a programmable threshold, the block fires. Firing subtracts a programmable feedback weight from the accumulator instead of clearing it. The leftover charge therefore carries into later samples. This keeps the quantization error bounded and pushes it towards high frequencies.

A 24-bit spike counter and a 24-bit running sum of the accepted inputs are exposed. With the feedback weight equal to the threshold, the running sum minus threshold times spike count equals the residual charge. A checker outside the block can therefore confirm that the reconstruction error stays within one threshold step.

Top module: `sd_if_encoder`

## Requirements
- R1: Synchronous reset clears the membrane, `spike_count` and `input_sum` to zero and holds `spike` low.
- R2: In the cycle after each accepted sample (`in_valid` high), `input_sum` grows by the sign-extended `in_data`, wrapping modulo 2^24. It is unchanged after cycles without a sample.
- R3: In the cycle after an accepted sample, `spike` is high exactly when membrane + `in_data` is at least `threshold`. The comparison is signed, and `threshold` is unsigned.
- R4: On a firing sample the new membrane is membrane + `in_data` − `fb_weight`. It is never cleared to zero.
- R5: At most one spike follows each accepted sample. `spike` stays low after cycles without a sample, even when the stored membrane is at or above the threshold.
- R6: `spike_count` rises by exactly one after every spike and is otherwise unchanged.
- R7: With `fb_weight` equal to `threshold` and every |`in_data`| ≤ `threshold`, the total integrated input minus `threshold` × `spike_count` stays below `threshold`. With non-negative inputs it also stays at or above zero.
- R8: The membrane may go negative, and no negative spike exists. Negative input produces no spikes, and later positive input must first repay the deficit.
- R9: Charge still at or above the threshold after one subtraction is held. It produces a further spike on each following accepted sample, even when that sample is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed sample |
| threshold | input | 16 | Unsigned firing level |
| fb_weight | input | 16 | Unsigned charge removed per spike |
| spike | output | 1 | One-bit spike for the last accepted sample |
| spike_count | output | 24 | Total spikes since reset, wrapping |
| input_sum | output | 24 | Sum of accepted samples since reset, wrapping |

## Verification
The bound assertions check four things on every cycle. The spike stays silent without a sample. The counter and the input sum move only in step with spikes and samples. A firing step leaves exactly the feedback weight missing from the membrane. A fired spike always had reached the threshold. Only the bench's scenarios can show the error bound of the loop as a whole. They also show that negative deficits are repaid, that held-over charge fires on later zero samples, and that subtraction differs from clearing. The bench covers these with exhaustive sweeps over small thresholds.

// File: rtl/sd_if_encoder.sv
module sd_if_encoder #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic        [THR_W-1:0]  threshold,
  input  logic        [THR_W-1:0]  fb_weight,
  output logic                     spike,
  output logic        [CNT_W-1:0]  spike_count,
  output logic        [CNT_W-1:0]  input_sum
);
  localparam int AEXT = ACC_W - DATA_W;
  localparam int TEXT = ACC_W - THR_W;
  localparam int SEXT = CNT_W - DATA_W;

  logic signed [ACC_W-1:0] membrane;
  logic signed [ACC_W-1:0] data_ext, thr_ext, wgt_ext, charged;
  logic                    fire;

  assign data_ext = {{AEXT{in_data[DATA_W-1]}}, in_data};
  assign thr_ext  = {{TEXT{1'b0}}, threshold};
  assign wgt_ext  = {{TEXT{1'b0}}, fb_weight};
  assign charged  = membrane + data_ext;
  assign fire     = in_valid && (charged >= thr_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      membrane    <= '0;
      spike       <= 1'b0;
      spike_count <= '0;
      input_sum   <= '0;
    end else begin
      spike <= fire;
      if (in_valid) begin
        membrane  <= fire ? charged - wgt_ext : charged;
        input_sum <= input_sum + {{SEXT{in_data[DATA_W-1]}}, in_data};
      end
      if (fire) spike_count <= spike_count + 1'b1;
    end
  end
endmodule

// File: rtl/sd_if_encoder_chk.sv
module sd_if_encoder_chk #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_data,
  input logic        [THR_W-1:0]  threshold,
  input logic        [THR_W-1:0]  fb_weight,
  input logic                     spike,
  input logic        [CNT_W-1:0]  spike_count,
  input logic        [CNT_W-1:0]  input_sum,
  input logic signed [ACC_W-1:0]  membrane
);
  logic signed [ACC_W-1:0] d_x, t_x, w_x;
  logic        [CNT_W-1:0] d_s;
  assign d_x = ACC_W'(in_data);
  assign t_x = ACC_W'({1'b0, threshold});
  assign w_x = ACC_W'({1'b0, fb_weight});
  assign d_s = CNT_W'(in_data);

  // R5
  quiet_without_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !spike);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> spike_count == $past(spike_count) + CNT_W'(spike));

  // R2
  sum_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> input_sum == $past(input_sum) + ($past(in_valid) ? $past(d_s) : '0));

  // R4
  subtract_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && spike) |-> membrane == $past(membrane) + $past(d_x) - $past(w_x));

  // R3
  fire_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && spike) |-> ($past(membrane) + $past(d_x) >= $past(t_x)));
endmodule

bind sd_if_encoder sd_if_encoder_chk #(
  .DATA_W(DATA_W), .THR_W(THR_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .threshold(threshold), .fb_weight(fb_weight), .spike(spike),
  .spike_count(spike_count), .input_sum(input_sum), .membrane(membrane)
);

// File: tb/sd_if_encoder_test.sv
module sd_if_encoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic [15:0] threshold = 16'd1;
  logic [15:0] fb_weight = 16'd1;
  logic spike;
  logic [23:0] spike_count, input_sum;

  int compared = 0;
  int mismatched = 0;
  longint m_mem, m_tot;
  logic [23:0] m_cnt, m_sum;
  logic m_spk;

  always #2.5 clk = ~clk;

  sd_if_encoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .threshold(threshold), .fb_weight(fb_weight), .spike(spike),
    .spike_count(spike_count), .input_sum(input_sum)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_mem = 0; m_tot = 0; m_cnt = '0; m_sum = '0; m_spk = 1'b0;
  endtask

  task automatic step(input logic v, input int d);
    in_valid = v; in_data = 16'(d);
    @(negedge clk);
    m_spk = 1'b0;
    if (v) begin
      m_mem = m_mem + d;
      m_tot = m_tot + d;
      m_sum = m_sum + 24'(d);
      if (m_mem >= longint'(threshold)) begin
        m_spk = 1'b1;
        m_mem = m_mem - longint'(fb_weight);
        m_cnt = m_cnt + 1'b1;
      end
    end
    in_valid = 1'b0;
    chk("R3 spike", spike, m_spk);
    chk("R6 count", spike_count, m_cnt);
    chk("R2 sum", input_sum, m_sum);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 spike", spike, 0);
    chk("R1 count", spike_count, 0);
    chk("R1 sum", input_sum, 0);

    for (int t = 1; t <= 6; t++) begin
      threshold = 16'(t); fb_weight = 16'(t);
      do_reset();
      for (int a = 0; a <= t; a++)
        for (int b = 0; b <= t; b++) begin
          step(1'b1, a); step(1'b1, b);
          chk("R7 upper", (m_tot - t * longint'(spike_count)) < t, 1);
          chk("R7 lower", (m_tot - t * longint'(spike_count)) >= 0, 1);
        end
      do_reset();
      for (int a = -t; a <= t; a++)
        for (int b = -t; b <= t; b++) begin
          step(1'b1, a); step(1'b1, b);
          chk("R7 upper signed", (m_tot - t * longint'(spike_count)) < t, 1);
        end
    end

    threshold = 16'd4; fb_weight = 16'd4;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      step(1'b1, -4);
      chk("R8 no spike on negative", spike, 0);
    end
    for (int i = 0; i < 8; i++) step(1'b1, 4);
    chk("R8 repay count", spike_count, 3);

    threshold = 16'd4; fb_weight = 16'd1;
    do_reset();
    step(1'b1, 4); step(1'b1, 4);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 0);
      chk("R5 no spike idle", spike, 0);
      chk("R5 count held", spike_count, 2);
    end
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 0);
      chk("R9 held charge fires", spike, 1);
    end
    step(1'b1, 0);
    chk("R9 charge spent", spike, 0);

    threshold = 16'd10; fb_weight = 16'd10;
    do_reset();
    step(1'b1, 7); step(1'b1, 7); step(1'b1, 6);
    chk("R4 residual kept", spike, 1);

    step(1'b1, 9);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 mid-run count", spike_count, 0);
    chk("R1 mid-run sum", input_sum, 0);
    chk("R1 mid-run spike", spike, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule